// File: doc/BRIEF.md
# Signed-Magnitude Adder/Subtractor

This block adds or subtracts two operands held in sign-and-magnitude form. Each operand arrives as an unsigned magnitude and a separate sign bit (0 means positive). A single select input picks addition or subtraction. The result is left in an accumulator made of a magnitude register and a sign register. Beside the accumulator sit an end-carry flag and an add-overflow flag.

The effective operation is set by the two signs and the select. When the magnitudes must be combined, one adder forms their sum. When they must be differenced, the same adder forms A plus the inverted B plus one. A missing end-carry shows that B was the larger operand. In that case the accumulator is replaced by its two's complement and its sign is flipped. This takes one extra cycle. A difference of zero always leaves a positive sign.

The block starts an operation on a start pulse and raises done for exactly one cycle when the accumulator is valid.

Top module: `smag_addsub_unit`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, done, res_mag, res_sign, carry_e and add_ovf are all 0.
- R2: The magnitudes are differenced when op_sub XOR a_sign XOR b_sign is 1, and summed otherwise. op_sub = 0 selects addition and op_sub = 1 selects subtraction.
- R3: For a magnitude sum, res_mag = (a_mag + b_mag) mod 2^MAG_W. carry_e and add_ovf both equal the end-carry, res_sign = a_sign, and done rises one clock after the start edge.
- R4: For a magnitude difference with a_mag >= b_mag, res_mag = a_mag - b_mag, carry_e = 1, add_ovf = 0, res_sign = a_sign, and done rises one clock after the start edge.
- R5: For a magnitude difference with a_mag < b_mag, res_mag = b_mag - a_mag, res_sign = NOT a_sign, carry_e = 0, add_ovf = 0, and done rises two clocks after the start edge.
- R6: A magnitude difference whose result is zero always gives res_sign = 0.
- R7: done stays high for exactly one clock per accepted operation.
- R8: A start that arrives while a recomplement cycle is pending is ignored. The result delivered is that of the first operation.
- R9: Between operations, res_mag, res_sign, carry_e and add_ovf keep their values until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| a_mag | input | MAG_W | Magnitude of operand A |
| a_sign | input | 1 | Sign of operand A, 1 = negative |
| b_mag | input | MAG_W | Magnitude of operand B |
| b_sign | input | 1 | Sign of operand B, 1 = negative |
| res_mag | output | MAG_W | Accumulator magnitude |
| res_sign | output | 1 | Accumulator sign |
| carry_e | output | 1 | End-carry of the last magnitude operation |
| add_ovf | output | 1 | Overflow of a magnitude sum |
| done | output | 1 | One-cycle pulse when the accumulator is valid |

## Verification
Some properties are checked on every cycle. done is a single-cycle pulse. A difference never raises add_ovf, and a sum reports its overflow through the end-carry. A zero difference carries a positive sign. The recomplement cycle inverts the sign and completes the operation. The accumulator holds steady while idle.

The numeric correctness of each case can only be shown by the bench's scenarios, because it depends on operand values. These cases are the sign pairings under both selects, wrap-around sums, equal magnitudes, negative zero, and the extra cycle taken by a borrowing difference. The bench also shows that a start issued during the recomplement cycle is dropped.

// File: rtl/smag_pkg.sv
package smag_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FIX  = 1'b1
  } smag_state_e;
endpackage

// File: rtl/smag_sign_cmp.sv
module smag_sign_cmp (
  input  logic op_sub,
  input  logic a_sign,
  input  logic b_sign,
  output logic diff_mags
);
  // signs differing flips the sense of the requested operation
  logic signs_differ;
  always_comb begin
    signs_differ = a_sign ^ b_sign;
    diff_mags    = signs_differ ^ op_sub;
  end
endmodule

// File: rtl/smag_cmpl_adder.sv
module smag_cmpl_adder #(
  parameter int unsigned MAG_W = 8
) (
  input  logic [MAG_W-1:0] x,
  input  logic [MAG_W-1:0] y,
  input  logic             invert_y,
  output logic [MAG_W-1:0] sum,
  output logic             cout
);
  logic [MAG_W-1:0] y_sel;

  // per-bit complementer: XOR with the mode bit
  for (genvar i = 0; i < MAG_W; i++) begin : g_cmpl
    assign y_sel[i] = y[i] ^ invert_y;
  end

  logic [MAG_W:0] wide;
  always_comb begin
    wide = {1'b0, x} + {1'b0, y_sel} + {{MAG_W{1'b0}}, invert_y};
    sum  = wide[MAG_W-1:0];
    cout = wide[MAG_W];
  end
endmodule

// File: rtl/smag_recomp.sv
module smag_recomp #(
  parameter int unsigned MAG_W = 8
) (
  input  logic [MAG_W-1:0] val,
  output logic [MAG_W-1:0] neg
);
  always_comb neg = ~val + {{(MAG_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/smag_addsub_unit.sv
module smag_addsub_unit
  import smag_pkg::*;
#(
  parameter int unsigned MAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_sub,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             a_sign,
  input  logic [MAG_W-1:0] b_mag,
  input  logic             b_sign,
  output logic [MAG_W-1:0] res_mag,
  output logic             res_sign,
  output logic             carry_e,
  output logic             add_ovf,
  output logic             done
);
  localparam logic [MAG_W-1:0] MAG_ZERO = '0;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  // datapath pieces
  logic             diff_mags;
  logic [MAG_W-1:0] add_sum;
  logic             add_cout;
  logic [MAG_W-1:0] acc_neg;

  smag_sign_cmp u_sign_cmp (
    .op_sub    (op_sub),
    .a_sign    (a_sign),
    .b_sign    (b_sign),
    .diff_mags (diff_mags)
  );

  smag_cmpl_adder #(.MAG_W(MAG_W)) u_adder (
    .x        (a_mag),
    .y        (b_mag),
    .invert_y (diff_mags),
    .sum      (add_sum),
    .cout     (add_cout)
  );

  // state
  smag_state_e      st_q, st_d;
  logic [MAG_W-1:0] acc_q, acc_d;
  logic             sgn_q, sgn_d;
  logic             e_q, e_d;
  logic             avf_q, avf_d;
  logic             sub_q, sub_d;
  logic             done_q, done_d;
  logic             acc_en;

  smag_recomp #(.MAG_W(MAG_W)) u_recomp (
    .val (acc_q),
    .neg (acc_neg)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    acc_d  = acc_q;
    sgn_d  = sgn_q;
    e_d    = e_q;
    avf_d  = avf_q;
    sub_d  = sub_q;
    done_d = 1'b0;
    acc_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          acc_en = 1'b1;
          acc_d  = add_sum;
          e_d    = add_cout;
          sub_d  = diff_mags;
          avf_d  = diff_mags ? 1'b0 : add_cout;
          if (diff_mags && add_sum == MAG_ZERO) sgn_d = 1'b0;
          else                                  sgn_d = a_sign;
          if (diff_mags && !add_cout) st_d = ST_FIX;
          else                        done_d = 1'b1;
        end
      end
      ST_FIX: begin
        acc_en = 1'b1;
        acc_d  = acc_neg;
        sgn_d  = ~sgn_q;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      st_q   <= ST_IDLE;
      acc_q  <= '0;
      sgn_q  <= 1'b0;
      e_q    <= 1'b0;
      avf_q  <= 1'b0;
      sub_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (acc_en) begin
        acc_q <= acc_d;
        sgn_q <= sgn_d;
        e_q   <= e_d;
        avf_q <= avf_d;
        sub_q <= sub_d;
      end
    end
  end

  assign res_mag  = acc_q;
  assign res_sign = sgn_q;
  assign carry_e  = e_q;
  assign add_ovf  = avf_q;
  assign done     = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);

  // R5
  recomp_sign_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_q == ST_FIX) |=> (done && res_sign == !$past(res_sign) && !carry_e));

  // R4
  diff_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && sub_q) |-> !add_ovf);

  // R3
  sum_ovf_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && !sub_q) |-> (add_ovf == carry_e));

  // R6
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (done && sub_q && res_mag == MAG_ZERO) |-> !res_sign);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_q == ST_FIX && start) |=> $stable(sub_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (st_q == ST_IDLE && !start) |=> ($stable(res_mag) && $stable(res_sign)
                                     && $stable(carry_e) && $stable(add_ovf)));
endmodule

// File: tb/smag_addsub_unit_bench.sv
module smag_addsub_unit_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, op_sub, a_sign, b_sign;
  logic [W-1:0] a_mag, b_mag;
  logic [W-1:0] res_mag;
  logic         res_sign, carry_e, add_ovf, done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  smag_addsub_unit #(.MAG_W(W)) u_smag_addsub_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .a_mag(a_mag), .a_sign(a_sign), .b_mag(b_mag), .b_sign(b_sign),
    .res_mag(res_mag), .res_sign(res_sign), .carry_e(carry_e),
    .add_ovf(add_ovf), .done(done)
  );

  // {op_sub, a_sign, a_mag, b_sign, b_mag, exp_sign, exp_mag, exp_e, exp_avf, exp_lat}
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd5,   1'b0, 8'd3,   1'b0, 8'd8,   1'b0, 1'b0, 2'd1}, // R3 plain sum
    {1'b0, 1'b1, 8'd200, 1'b1, 8'd100, 1'b1, 8'd44,  1'b1, 1'b1, 2'd1}, // R3 overflow
    {1'b0, 1'b0, 8'd20,  1'b1, 8'd7,   1'b0, 8'd13,  1'b1, 1'b0, 2'd1}, // R2 R4
    {1'b0, 1'b0, 8'd7,   1'b1, 8'd20,  1'b1, 8'd13,  1'b0, 1'b0, 2'd2}, // R5
    {1'b1, 1'b0, 8'd30,  1'b0, 8'd10,  1'b0, 8'd20,  1'b1, 1'b0, 2'd1}, // R2 R4 sub
    {1'b1, 1'b1, 8'd10,  1'b1, 8'd30,  1'b0, 8'd20,  1'b0, 1'b0, 2'd2}, // R5 sub
    {1'b1, 1'b0, 8'd50,  1'b1, 8'd60,  1'b0, 8'd110, 1'b0, 1'b0, 2'd1}, // R2 sub adds
    {1'b1, 1'b1, 8'd42,  1'b1, 8'd42,  1'b0, 8'd0,   1'b1, 1'b0, 2'd1}, // R6
    {1'b0, 1'b1, 8'd0,   1'b0, 8'd0,   1'b0, 8'd0,   1'b1, 1'b0, 2'd1}, // R6 neg zero
    {1'b0, 1'b0, 8'd0,   1'b1, 8'd255, 1'b1, 8'd255, 1'b0, 1'b0, 2'd2}, // R5 extreme
    {1'b0, 1'b1, 8'd255, 1'b1, 8'd1,   1'b1, 8'd0,   1'b1, 1'b1, 2'd1}, // R3 wrap to zero
    {1'b1, 1'b0, 8'd255, 1'b1, 8'd255, 1'b0, 8'd254, 1'b1, 1'b1, 2'd1}  // R3 max
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // drive one operation, wait for done, report latency in cycles
  task automatic run_op(input logic op, input logic as, input logic [W-1:0] am,
                        input logic bs, input logic [W-1:0] bm, output int lat);
    @(negedge clk);
    op_sub = op; a_sign = as; a_mag = am; b_sign = bs; b_mag = bm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 4) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; start = 1'b0; op_sub = 1'b0;
    a_sign = 1'b0; b_sign = 1'b0; a_mag = '0; b_mag = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", done, 0);
    chk("R1", "res_mag", res_mag, 0);
    chk("R1", "res_sign", res_sign, 0);
    chk("R1", "carry_e", carry_e, 0);
    chk("R1", "add_ovf", add_ovf, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done after release", done, 0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      run_op(v[31], v[30], v[29:22], v[21], v[20:13], lat);
      chk("R2", $sformatf("vec%0d mag", i), res_mag, v[11:4]);
      chk("R2", $sformatf("vec%0d sign", i), res_sign, v[12]);
      chk("R3", $sformatf("vec%0d carry_e", i), carry_e, v[3]);
      chk("R4", $sformatf("vec%0d add_ovf", i), add_ovf, v[2]);
      chk("R5", $sformatf("vec%0d latency", i), lat, v[1:0]);
      @(negedge clk);
      chk("R7", $sformatf("vec%0d done width", i), done, 0);
    end

    // R8: second start during recomplement cycle is dropped
    @(negedge clk);
    op_sub = 1'b0; a_sign = 1'b1; a_mag = 8'd3; b_sign = 1'b0; b_mag = 8'd9;
    start = 1'b1;
    @(negedge clk);
    op_sub = 1'b0; a_sign = 1'b0; a_mag = 8'd1; b_sign = 1'b0; b_mag = 8'd1;
    chk("R8", "done during fix", done, 0);
    @(negedge clk);
    start = 1'b0;
    chk("R8", "done after fix", done, 1);
    chk("R8", "mag of first op", res_mag, 6);
    chk("R8", "sign of first op", res_sign, 0);
    @(negedge clk);
    chk("R8", "no second done", done, 0);

    // R9: accumulator holds while idle and inputs move
    a_mag = 8'd77; b_mag = 8'd12; op_sub = 1'b1; a_sign = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "held mag", res_mag, 6);
    chk("R9", "held sign", res_sign, 0);
    chk("R9", "held carry", carry_e, 0);
    chk("R9", "idle done", done, 0);

    // R1: reset mid-stream clears accumulator
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mag after reset", res_mag, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule